// File: doc/BRIEF.md
# Five-Word Coefficient and Control Register Loader

This block runs on its own load clock and turns a stream of 12-bit words into single write strobes for three kinds of storage: one row spread across four coefficient banks, one of sixteen 32-bit rounding registers, or one of sixteen 32-bit clamp registers that each hold a lower and an upper bound. A transaction is five words long. The first word is a header that names the target, and the next four are payload. The storage arrays themselves sit outside this block; it drives only their write ports.

A word is taken on a rising load-clock edge only while the active-low load input `ld_n` is LOW. After reset the loader stays unarmed until it has seen `ld_n` HIGH, so the first capture always follows a HIGH-to-LOW transition. Payload words are held in a buffer, and the target is written in one step only once the last payload word has arrived. Transactions may run back to back while `ld_n` stays LOW. Raising `ld_n` partway through a transaction discards it.

The controller has three states. `ST_UNARMED` moves to `ST_HEADER` on an edge with `ld_n` HIGH. `ST_HEADER` moves to `ST_DATA` on an edge with `ld_n` LOW and captures the header. `ST_DATA` counts four payload words. On the fourth it commits and returns to `ST_HEADER`. An edge with `ld_n` HIGH in any armed state also returns it to `ST_HEADER` (the abort path).

Top module: `coef_ctrl_loader`

## Requirements
- R1: While `ld_rst_n` is LOW, all three write strobes and all write-port fields are 0, and the loader is unarmed.
- R2: After reset, words presented with `ld_n` LOW are ignored until an edge with `ld_n` HIGH has been seen. No strobe fires and no field changes.
- R3: No word is captured on an edge with `ld_n` HIGH. The cycle that follows such an edge has no write strobe.
- R4: A header with bit 11 = 0 is a coefficient write, and header bits 7-0 give `coef_row`. Payload words 1 to 4 appear on `coef_wdata[0]` to `coef_wdata[3]`, which are banks 1 to 4. `coef_we` is high for exactly the one cycle that follows the edge capturing the fourth payload word.
- R5: A header with bit 11 = 1 and bit 4 = 0 is a rounding-register write, and bits 3-0 give `rnd_idx`. `rnd_value` is built from the low 8 bits of payload words 1 to 4, with word 1 as the most significant byte. Bits 11-8 of the payload words are ignored.
- R6: A header with bit 11 = 1 and bit 4 = 1 is a clamp-register write, and bits 3-0 give `lim_idx`. The 32-bit value is assembled as in R5. Its bits 31-16 drive `lim_upper` and its bits 15-0 drive `lim_lower`.
- R7: No strobe fires before the fourth payload word has been captured. At most one strobe is high in any cycle, and no strobe is high in two consecutive cycles.
- R8: After a commit, the next word captured with `ld_n` LOW is taken as a new header, so transactions chain without `ld_n` going HIGH.
- R9: If `ld_n` goes HIGH before the fourth payload word, the partial transaction is dropped and nothing is written. The next LOW word is a header.
- R10: Header bits 10-8 are ignored for coefficient writes, and bits 10-5 are ignored for control writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ld_clk | input | 1 | Load clock; every register samples on its rising edge |
| ld_rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Active-low load qualifier |
| word_in | input | 12 | Header or payload word |
| coef_we | output | 1 | One-cycle coefficient-row write strobe |
| coef_row | output | 8 | Coefficient row address |
| coef_wdata | output | 4x12 | Coefficient words; element 0 is bank 1 |
| rnd_we | output | 1 | One-cycle rounding-register write strobe |
| rnd_idx | output | 4 | Rounding-register index |
| rnd_value | output | 32 | Rounding-register value |
| lim_we | output | 1 | One-cycle clamp-register write strobe |
| lim_idx | output | 4 | Clamp-register index |
| lim_lower | output | 16 | Lower bound (value bits 15-0) |
| lim_upper | output | 16 | Upper bound (value bits 31-16) |

## Verification
Every output comes from a register, so a strobe and its fields appear in the cycle that follows the rising edge that captured the fourth payload word, exactly one register stage later. An edge with `ld_n` HIGH affects only what later edges do. The bench drives inputs on falling edges and keeps a behavioural model that it advances on each rising edge. It compares every output against that model on the next falling edge, so each result is checked in the very cycle it is due, and any early, late or extra strobe counts as a mismatch.

// File: rtl/ldr_pkg.sv
`timescale 1ns/1ps
package ldr_pkg;

    typedef enum logic [1:0] {
        ST_UNARMED = 2'd0,
        ST_HEADER  = 2'd1,
        ST_DATA    = 2'd2
    } ldr_state_e;

endpackage

// File: rtl/ldr_fsm.sv
`timescale 1ns/1ps
module ldr_fsm
    import ldr_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_n,
    output logic                 hdr_en,
    output logic [NUM_BANKS-2:0] slot_en,
    output logic                 commit
);
    localparam int CNT_W = $clog2(NUM_BANKS);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(NUM_BANKS - 1);

    ldr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_UNARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_UNARMED: if (ld_n) state_d = ST_HEADER;
            ST_HEADER: begin
                if (!ld_n) begin
                    state_d = ST_DATA;
                    cnt_d   = '0;
                end
            end
            ST_DATA: begin
                if (ld_n || (cnt_q == LAST_SLOT)) state_d = ST_HEADER;
                else                              cnt_d   = cnt_q + 1'b1;
            end
            default: state_d = ST_UNARMED;
        endcase
    end

    // outputs
    always_comb begin
        hdr_en  = (state_q == ST_HEADER) && !ld_n;
        commit  = (state_q == ST_DATA) && !ld_n && (cnt_q == LAST_SLOT);
        slot_en = '0;
        for (int i = 0; i < NUM_BANKS - 1; i++) begin
            slot_en[i] = (state_q == ST_DATA) && !ld_n && (cnt_q == CNT_W'(i));
        end
    end

    // R2
    unarmed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNARMED && !ld_n) |=> (state_q == ST_UNARMED));
    // R9
    abort_to_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> (state_q == ST_HEADER));
    // R8
    commit_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (state_q == ST_HEADER));
    // R7
    single_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hdr_en, slot_en, commit}));

endmodule

// File: rtl/ldr_buffer.sv
`timescale 1ns/1ps
module ldr_buffer #(
    parameter int WORD_W    = 12,
    parameter int ROW_W     = 8,
    parameter int NUM_BANKS = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [WORD_W-1:0]                    word_in,
    input  logic                                 hdr_en,
    input  logic [NUM_BANKS-2:0]                 slot_en,
    output logic                                 hdr_ctl,
    output logic [ROW_W-1:0]                     hdr_low,
    output logic [NUM_BANKS-2:0][WORD_W-1:0]     slot_q
);
    // header keeps only the bits that are decoded
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_ctl <= 1'b0;
            hdr_low <= '0;
        end else if (hdr_en) begin
            hdr_ctl <= word_in[WORD_W-1];
            hdr_low <= word_in[ROW_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_BANKS - 1; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          slot_q[g] <= '0;
            else if (slot_en[g]) slot_q[g] <= word_in;
        end
    end

endmodule

// File: rtl/ldr_commit.sv
`timescale 1ns/1ps
module ldr_commit #(
    parameter int WORD_W    = 12,
    parameter int ROW_W     = 8,
    parameter int NUM_BANKS = 4,
    parameter int REG_IDX_W = 4,
    parameter int REG_W     = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ld_n,
    input  logic                             commit,
    input  logic [WORD_W-1:0]                word_in,
    input  logic                             hdr_ctl,
    input  logic [ROW_W-1:0]                 hdr_low,
    input  logic [NUM_BANKS-2:0][WORD_W-1:0] slot_q,
    output logic                             coef_we,
    output logic [ROW_W-1:0]                 coef_row,
    output logic [NUM_BANKS-1:0][WORD_W-1:0] coef_wdata,
    output logic                             rnd_we,
    output logic [REG_IDX_W-1:0]             rnd_idx,
    output logic [REG_W-1:0]                 rnd_value,
    output logic                             lim_we,
    output logic [REG_IDX_W-1:0]             lim_idx,
    output logic [REG_W/2-1:0]               lim_lower,
    output logic [REG_W/2-1:0]               lim_upper
);
    localparam int BYTE_W  = REG_W / NUM_BANKS;
    localparam int HALF_W  = REG_W / 2;
    localparam int SEL_BIT = REG_IDX_W;

    logic [NUM_BANKS-1:0][WORD_W-1:0] all_words;
    logic [REG_W-1:0]                 reg_val;

    always_comb begin
        for (int i = 0; i < NUM_BANKS - 1; i++) all_words[i] = slot_q[i];
        all_words[NUM_BANKS-1] = word_in;
        for (int i = 0; i < NUM_BANKS; i++) begin
            reg_val[REG_W-1-i*BYTE_W -: BYTE_W] = all_words[i][BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coef_we    <= 1'b0;
            coef_row   <= '0;
            coef_wdata <= '0;
            rnd_we     <= 1'b0;
            rnd_idx    <= '0;
            rnd_value  <= '0;
            lim_we     <= 1'b0;
            lim_idx    <= '0;
            lim_lower  <= '0;
            lim_upper  <= '0;
        end else begin
            coef_we <= 1'b0;
            rnd_we  <= 1'b0;
            lim_we  <= 1'b0;
            if (commit) begin
                if (!hdr_ctl) begin
                    coef_we    <= 1'b1;
                    coef_row   <= hdr_low;
                    coef_wdata <= all_words;
                end else if (hdr_low[SEL_BIT]) begin
                    lim_we     <= 1'b1;
                    lim_idx    <= hdr_low[REG_IDX_W-1:0];
                    lim_lower  <= reg_val[HALF_W-1:0];
                    lim_upper  <= reg_val[REG_W-1:HALF_W];
                end else begin
                    rnd_we     <= 1'b1;
                    rnd_idx    <= hdr_low[REG_IDX_W-1:0];
                    rnd_value  <= reg_val;
                end
            end
        end
    end

    // R7
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({coef_we, rnd_we, lim_we}));
    // R7
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_we || rnd_we || lim_we) |=> !(coef_we || rnd_we || lim_we));
    // R3
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> !(coef_we || rnd_we || lim_we));
    // R4
    last_bank_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coef_we |-> (coef_wdata[NUM_BANKS-1] == $past(word_in)));
    // R6
    lower_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lim_we |-> (lim_lower[BYTE_W-1:0] == $past(word_in[BYTE_W-1:0])));

endmodule

// File: rtl/coef_ctrl_loader.sv
`timescale 1ns/1ps
module coef_ctrl_loader #(
    parameter int WORD_W    = 12,
    parameter int ROW_W     = 8,
    parameter int NUM_BANKS = 4,
    parameter int REG_IDX_W = 4,
    parameter int REG_W     = 32
) (
    input  logic                             ld_clk,
    input  logic                             ld_rst_n,
    input  logic                             ld_n,
    input  logic [WORD_W-1:0]                word_in,
    output logic                             coef_we,
    output logic [ROW_W-1:0]                 coef_row,
    output logic [NUM_BANKS-1:0][WORD_W-1:0] coef_wdata,
    output logic                             rnd_we,
    output logic [REG_IDX_W-1:0]             rnd_idx,
    output logic [REG_W-1:0]                 rnd_value,
    output logic                             lim_we,
    output logic [REG_IDX_W-1:0]             lim_idx,
    output logic [REG_W/2-1:0]               lim_lower,
    output logic [REG_W/2-1:0]               lim_upper
);
    logic                             hdr_en;
    logic [NUM_BANKS-2:0]             slot_en;
    logic                             commit;
    logic                             hdr_ctl;
    logic [ROW_W-1:0]                 hdr_low;
    logic [NUM_BANKS-2:0][WORD_W-1:0] slot_q;

    ldr_fsm #(.NUM_BANKS(NUM_BANKS)) fsm_i (
        .clk     (ld_clk),
        .rst_n   (ld_rst_n),
        .ld_n    (ld_n),
        .hdr_en  (hdr_en),
        .slot_en (slot_en),
        .commit  (commit)
    );

    ldr_buffer #(.WORD_W(WORD_W), .ROW_W(ROW_W), .NUM_BANKS(NUM_BANKS)) buf_i (
        .clk     (ld_clk),
        .rst_n   (ld_rst_n),
        .word_in (word_in),
        .hdr_en  (hdr_en),
        .slot_en (slot_en),
        .hdr_ctl (hdr_ctl),
        .hdr_low (hdr_low),
        .slot_q  (slot_q)
    );

    ldr_commit #(
        .WORD_W(WORD_W), .ROW_W(ROW_W), .NUM_BANKS(NUM_BANKS),
        .REG_IDX_W(REG_IDX_W), .REG_W(REG_W)
    ) commit_i (
        .clk        (ld_clk),
        .rst_n      (ld_rst_n),
        .ld_n       (ld_n),
        .commit     (commit),
        .word_in    (word_in),
        .hdr_ctl    (hdr_ctl),
        .hdr_low    (hdr_low),
        .slot_q     (slot_q),
        .coef_we    (coef_we),
        .coef_row   (coef_row),
        .coef_wdata (coef_wdata),
        .rnd_we     (rnd_we),
        .rnd_idx    (rnd_idx),
        .rnd_value  (rnd_value),
        .lim_we     (lim_we),
        .lim_idx    (lim_idx),
        .lim_lower  (lim_lower),
        .lim_upper  (lim_upper)
    );

endmodule

// File: tb/coef_ctrl_loader_tb_top.sv
`timescale 1ns/1ps
module coef_ctrl_loader_tb_top;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ld_n;
    logic [11:0]       word_in;
    logic              coef_we, rnd_we, lim_we;
    logic [7:0]        coef_row;
    logic [3:0][11:0]  coef_wdata;
    logic [3:0]        rnd_idx, lim_idx;
    logic [31:0]       rnd_value;
    logic [15:0]       lim_lower, lim_upper;

    always #2.5 clk = ~clk;

    coef_ctrl_loader dut_i (
        .ld_clk(clk), .ld_rst_n(rst_n), .ld_n(ld_n), .word_in(word_in),
        .coef_we(coef_we), .coef_row(coef_row), .coef_wdata(coef_wdata),
        .rnd_we(rnd_we), .rnd_idx(rnd_idx), .rnd_value(rnd_value),
        .lim_we(lim_we), .lim_idx(lim_idx), .lim_lower(lim_lower), .lim_upper(lim_upper)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    // behavioural reference model
    logic [11:0]      q[$];
    bit               armed = 0;
    bit               e_cwe = 0, e_rwe = 0, e_lwe = 0;
    logic [7:0]       e_row = '0;
    logic [3:0][11:0] e_cdat = '0;
    logic [3:0]       e_ridx = '0, e_lidx = '0;
    logic [31:0]      e_rval = '0, e_lval = '0;

    always @(posedge clk) begin
        logic [31:0] v;
        e_cwe = 0; e_rwe = 0; e_lwe = 0;
        if (!rst_n) begin
            armed = 0; q.delete();
            e_row = '0; e_cdat = '0; e_ridx = '0; e_lidx = '0; e_rval = '0; e_lval = '0;
        end else if (ld_n) begin
            armed = 1; q.delete();
        end else if (armed) begin
            q.push_back(word_in);
            if (q.size() == 5) begin
                v = {q[1][7:0], q[2][7:0], q[3][7:0], q[4][7:0]};
                if (!q[0][11]) begin
                    e_cwe = 1; e_row = q[0][7:0];
                    for (int k = 0; k < 4; k++) e_cdat[k] = q[k+1];
                end else if (q[0][4]) begin
                    e_lwe = 1; e_lidx = q[0][3:0]; e_lval = v;
                end else begin
                    e_rwe = 1; e_ridx = q[0][3:0]; e_rval = v;
                end
                q.delete();
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        chk({coef_we, rnd_we, lim_we} === {e_cwe, e_rwe, e_lwe}, "strobes",
            64'({coef_we, rnd_we, lim_we}), 64'({e_cwe, e_rwe, e_lwe}));
        chk({coef_row, coef_wdata} === {e_row, e_cdat}, "coef port",
            64'({coef_row, coef_wdata}), 64'({e_row, e_cdat}));
        chk({rnd_idx, rnd_value} === {e_ridx, e_rval}, "round port",
            64'({rnd_idx, rnd_value}), 64'({e_ridx, e_rval}));
        chk({lim_idx, lim_upper, lim_lower} === {e_lidx, e_lval}, "clamp port",
            64'({lim_idx, lim_upper, lim_lower}), 64'({e_lidx, e_lval}));
    end

    task automatic put(input logic [11:0] w);
        ld_n = 1'b0; word_in = w;
        @(negedge clk);
    endtask

    task automatic idle(input int n, input logic [11:0] w);
        ld_n = 1'b1; word_in = w;
        repeat (n) @(negedge clk);
    endtask

    task automatic txn(input logic [11:0] h, input logic [11:0] a, input logic [11:0] b,
                       input logic [11:0] c, input logic [11:0] d);
        put(h); put(a); put(b); put(c); put(d);
    endtask

    initial begin
        rst_n = 1'b0; ld_n = 1'b0; word_in = '0;
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: load held LOW out of reset, loader must stay unarmed
        cur_req = "R2";
        txn(12'h00A, 12'hABC, 12'h789, 12'h456, 12'h123);
        put(12'h80A);
        // R3: load HIGH with changing words captures nothing
        cur_req = "R3";
        for (int i = 0; i < 6; i++) idle(1, 12'(i * 12'h111));
        // R4: coefficient row 10
        cur_req = "R4";
        txn(12'h00A, 12'hABC, 12'h789, 12'h456, 12'h123);
        idle(2, 12'h000);
        // R5: rounding register 10, junk in payload bits 11-8
        cur_req = "R5";
        txn(12'h80A, 12'hF76, 12'h054, 12'hA32, 12'h010);
        idle(2, 12'h000);
        // R6: clamp register 15, upper 7FED lower 0123
        cur_req = "R6";
        txn(12'h81F, 12'h07F, 12'hCED, 12'h001, 12'h923);
        idle(2, 12'h000);
        // R7: strobe only after the fourth payload word
        cur_req = "R7";
        txn(12'h0FF, 12'h800, 12'h001, 12'hFFF, 12'h7FF);
        idle(1, 12'h000);
        // R8: three chained transactions without load going HIGH
        cur_req = "R8";
        txn(12'h0FF, 12'h111, 12'h222, 12'h333, 12'h444);
        txn(12'h803, 12'h0DE, 12'h0AD, 12'h0BE, 12'h0EF);
        txn(12'h810, 12'h012, 12'h034, 12'h056, 12'h078);
        idle(2, 12'h000);
        // R9: aborts after two and after three payload words
        cur_req = "R9";
        put(12'h055); put(12'h001); put(12'h002);
        idle(1, 12'h000);
        put(12'h807); put(12'h0AA); put(12'h0BB); put(12'h0CC);
        idle(2, 12'h000);
        txn(12'h033, 12'h00F, 12'h0F0, 12'hF00, 12'h5A5);
        idle(2, 12'h000);
        // R10: ignored header bits
        cur_req = "R10";
        txn(12'h7A5, 12'h321, 12'h654, 12'h987, 12'hCBA);
        txn(12'hFE3, 12'h011, 12'h022, 12'h033, 12'h044);
        txn(12'hF35, 12'h080, 12'h000, 12'h07F, 12'h0FF);
        idle(3, 12'h000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL %s watchdog expired actual=running expected=done", cur_req);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule